// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column addresses of one synchronous DRAM read or write burst. A one-cycle start pulse captures three things: a start column, a two-bit length code and an ordering select. From the next cycle the block presents a column address with a valid flag. Each cycle in which the step enable is high consumes the presented beat, and the next address of the burst then appears. A flag marks the final beat of fixed-length bursts.

Fixed bursts of 2, 4 or 8 beats move only the low one, two or three column bits. Those bits either count upward and wrap inside the burst-aligned group, or follow the start offset XORed with a beat counter. All higher column bits hold their start value. A full-page burst counts through the whole row, wraps at the row's column count and continues until an abort. A new command stops a burst through the abort input. Requesting a full-page burst with interleaved ordering is an illegal configuration: the block reports it with a one-cycle error pulse and does not start a burst.

Top module: `burst_col_seq`

## Requirements
- R1: A start pulse with a legal configuration makes valid_o high in the next cycle, with col_o equal to the captured start column.
- R2: len_code_i selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8 and 3 gives a full page. A fixed burst presents exactly that many beats, and valid_o falls in the cycle after the last beat is consumed.
- R3: With ordering_i = 0 (sequential), beat k carries the low group bits (start + k) modulo the length. The group is bit 0 for length 2, bits 1..0 for length 4 and bits 2..0 for length 8. All bits above the group equal the start column.
- R4: With ordering_i = 1 (interleaved), beat k carries the low group bits (start XOR k). All bits above the group equal the start column.
- R5: last_o is high only while valid_o is high and the presented beat is the final beat of a fixed-length burst.
- R6: A full-page burst presents start + k modulo 2**COL_W on beat k. last_o is never high during it, and it runs until aborted.
- R7: A start with len_code_i = 3 and ordering_i = 1 raises cfg_err_o for exactly the next cycle, keeps valid_o low in that cycle and ends any burst in progress.
- R8: While step_en_i is low and no start or abort occurs, col_o and valid_o hold their values.
- R9: abort_i ends the burst, so valid_o is low in the next cycle. A start in the same cycle takes priority over abort_i.
- R10: During and right after reset, valid_o, last_o and cfg_err_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a burst with the configuration below |
| start_col_i | input | COL_W | Start column address |
| len_code_i | input | 2 | Burst length code: 0 = 2, 1 = 4, 2 = 8, 3 = full page |
| ordering_i | input | 1 | 0 = sequential, 1 = interleaved |
| step_en_i | input | 1 | Consume the presented beat and advance |
| abort_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Presented column address |
| valid_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | The presented beat is the last of a fixed burst |
| cfg_err_o | output | 1 | One-cycle pulse for an illegal configuration |

## Verification
The bench uses start columns with nonzero bits above the burst group. A design that carried into those bits, instead of wrapping inside the aligned group, would present columns from the wrong block. Interleaved bursts that start at odd offsets separate XOR ordering from addition, and a full-page burst placed near the top of the row checks the wrap to column zero and the absence of last_o. Stalls in the middle of a burst, an abort that arrives together with a start, and an illegal request during a running burst target designs that lose their position, give abort the wrong priority or keep presenting beats after an error.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
   typedef enum logic [1:0] {
      BL_TWO   = 2'd0,
      BL_FOUR  = 2'd1,
      BL_EIGHT = 2'd2,
      BL_PAGE  = 2'd3
   } burst_len_e;

   // widest fixed burst group, in address bits
   localparam int unsigned GROUP_BITS = 3;
endpackage

// File: rtl/burst_len_decode.sv
`timescale 1ns/1ps
module burst_len_decode
   import burst_seq_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  burst_len_e          len_code,
   input  logic                ordering,
   output logic [COL_W-1:0]    wrap_mask,
   output logic                is_page,
   output logic                illegal
);
   always_comb begin
      is_page = 1'b0;
      unique case (len_code)
         BL_TWO:   wrap_mask = COL_W'(1);
         BL_FOUR:  wrap_mask = COL_W'(3);
         BL_EIGHT: wrap_mask = COL_W'(7);
         default: begin
            wrap_mask = '1;
            is_page   = 1'b1;
         end
      endcase
   end

   assign illegal = is_page & ordering;
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
   import burst_seq_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] beat_cnt,
   input  logic [COL_W-1:0] wrap_mask,
   input  logic             ordering,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] sum;
   assign sum = base_col + beat_cnt;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      if (i < GROUP_BITS) begin : g_grp
         // burst group bit: sequential or XOR ordering
         assign col[i] = wrap_mask[i]
                         ? (ordering ? (base_col[i] ^ beat_cnt[i]) : sum[i])
                         : base_col[i];
      end else begin : g_row
         // only a full-page burst moves these bits
         assign col[i] = wrap_mask[i] ? sum[i] : base_col[i];
      end
   end
endmodule

// File: rtl/burst_beat_ctrl.sv
`timescale 1ns/1ps
module burst_beat_ctrl #(
   parameter int unsigned COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [COL_W-1:0] wrap_mask_i,
   input  logic             is_page_i,
   input  logic             illegal_i,
   input  logic             ordering_i,
   input  logic             step_en_i,
   input  logic             abort_i,
   output logic             active_o,
   output logic             final_o,
   output logic             err_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] cnt_o,
   output logic [COL_W-1:0] mask_o,
   output logic             page_o,
   output logic             ordering_o
);
   logic             active_q, err_q, page_q, ord_q;
   logic [COL_W-1:0] base_q, cnt_q, mask_q;
   logic             final_beat;

   // for fixed bursts the wrap mask equals the last beat index
   assign final_beat = active_q && !page_q && (cnt_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         err_q    <= 1'b0;
         page_q   <= 1'b0;
         ord_q    <= 1'b0;
         base_q   <= '0;
         cnt_q    <= '0;
         mask_q   <= '0;
      end else begin
         err_q <= 1'b0;
         if (start_i) begin
            if (illegal_i) begin
               active_q <= 1'b0;
               err_q    <= 1'b1;
            end else begin
               active_q <= 1'b1;
               cnt_q    <= '0;
               base_q   <= start_col_i;
               mask_q   <= wrap_mask_i;
               page_q   <= is_page_i;
               ord_q    <= ordering_i;
            end
         end else if (abort_i) begin
            active_q <= 1'b0;
         end else if (active_q && step_en_i) begin
            if (final_beat) active_q <= 1'b0;
            else            cnt_q    <= cnt_q + 1'b1;
         end
      end
   end

   assign active_o   = active_q;
   assign final_o    = final_beat;
   assign err_o      = err_q;
   assign base_o     = base_q;
   assign cnt_o      = cnt_q;
   assign mask_o     = mask_q;
   assign page_o     = page_q;
   assign ordering_o = ord_q;
endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq
   import burst_seq_pkg::*;
#(
   parameter int unsigned COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [1:0]       len_code_i,
   input  logic             ordering_i,
   input  logic             step_en_i,
   input  logic             abort_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             cfg_err_o
);
   if (COL_W < GROUP_BITS) begin : g_bad_width
      $error("burst_col_seq: COL_W must cover the 8-beat group");
   end

   logic [COL_W-1:0] dec_mask, base_q, cnt_q, mask_q;
   logic             dec_page, dec_illegal, ord_q;
   logic             page_mode;

   burst_len_decode #(.COL_W(COL_W)) u_dec (
      .len_code  (burst_len_e'(len_code_i)),
      .ordering  (ordering_i),
      .wrap_mask (dec_mask),
      .is_page   (dec_page),
      .illegal   (dec_illegal)
   );

   burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .wrap_mask_i (dec_mask),
      .is_page_i   (dec_page),
      .illegal_i   (dec_illegal),
      .ordering_i  (ordering_i),
      .step_en_i   (step_en_i),
      .abort_i     (abort_i),
      .active_o    (valid_o),
      .final_o     (last_o),
      .err_o       (cfg_err_o),
      .base_o      (base_q),
      .cnt_o       (cnt_q),
      .mask_o      (mask_q),
      .page_o      (page_mode),
      .ordering_o  (ord_q)
   );

   burst_addr_gen #(.COL_W(COL_W)) u_addr (
      .base_col  (base_q),
      .beat_cnt  (cnt_q),
      .wrap_mask (mask_q),
      .ordering  (ord_q),
      .col       (col_o)
   );
endmodule

// File: rtl/burst_col_seq_chk.sv
`timescale 1ns/1ps
module burst_col_seq_chk #(
   parameter int unsigned COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [1:0]       len_code_i,
   input logic             ordering_i,
   input logic             step_en_i,
   input logic             abort_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic             cfg_err_o,
   input logic             page_mode
);
   logic illegal_req;
   assign illegal_req = (len_code_i == 2'd3) && ordering_i;

   // R1
   start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !illegal_req |=> valid_o && (col_o == $past(start_col_i)));

   // R5
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o && !page_mode);

   // R7
   illegal_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && illegal_req |=> cfg_err_o && !valid_o);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !step_en_i && !start_i && !abort_i |=> valid_o && $stable(col_o));

   // R9
   abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i && !start_i |=> !valid_o);

   // R3
   upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && step_en_i && !last_o && !start_i && !abort_i && !page_mode
      |=> valid_o && ((col_o >> 3) == ($past(col_o) >> 3)));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .len_code_i  (len_code_i),
   .ordering_i  (ordering_i),
   .step_en_i   (step_en_i),
   .abort_i     (abort_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o),
   .cfg_err_o   (cfg_err_o),
   .page_mode   (page_mode)
);

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
   localparam int unsigned COL_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [1:0]       len_code_i = '0;
   logic             ordering_i = 1'b0;
   logic             step_en_i = 1'b0;
   logic             abort_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o, last_o, cfg_err_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   string cur_req = "R3";
   logic [COL_W:0] exp_q[$];   // {last, col}

   always #2 clk = ~clk;   // 250 MHz

   burst_col_seq #(.COL_W(COL_W)) dut (.*);

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected beat from the requirements (R3, R4, R6, R5)
   function automatic logic [COL_W:0] exp_beat(input int col, input int code,
                                               input bit il, input int k);
      int len, mask, off, a;
      bit lst;
      len  = (code == 3) ? (1 << COL_W) : (2 << code);
      mask = len - 1;
      off  = il ? (col ^ k) : (col + k);
      a    = ((col & ~mask) | (off & mask)) & ((1 << COL_W) - 1);
      lst  = (code != 3) && (k == len - 1);
      return {lst, a[COL_W-1:0]};
   endfunction

   // monitor: compare every consumed beat
   always @(negedge clk) begin
      if (rst_n && valid_o && step_en_i) begin
         if (exp_q.size() == 0) begin
            check("R2 unexpected beat", int'({last_o, col_o}), -1);
         end else begin
            logic [COL_W:0] e;
            e = exp_q.pop_front();
            check(cur_req, int'(col_o), int'(e[COL_W-1:0]));
            check({cur_req, "/R5 last"}, int'(last_o), int'(e[COL_W]));
         end
      end
   end

   task automatic launch(input int col, input int code, input bit il);
      start_i = 1'b1; start_col_i = COL_W'(col); len_code_i = 2'(code);
      ordering_i = il; step_en_i = 1'b0;
      @(posedge clk); #1;
      start_i = 1'b0;
   endtask

   task automatic run_burst(input int col, input int code, input bit il,
                            input int nbeats, input bit stall,
                            input bit use_abort, input string req);
      cur_req = req;
      launch(col, code, il);
      @(negedge clk);
      check("R1 valid", int'(valid_o), 1);
      check("R1 col", int'(col_o), col);
      @(posedge clk); #1;
      for (int k = 0; k < nbeats; k++) begin
         if (stall && k[0]) begin
            logic [COL_W:0] e;
            e = exp_beat(col, code, il, k);
            step_en_i = 1'b0;
            @(negedge clk);
            check("R8 hold", int'(col_o), int'(e[COL_W-1:0]));
            @(posedge clk); #1;
         end
         step_en_i = 1'b1;
         exp_q.push_back(exp_beat(col, code, il, k));
         @(posedge clk); #1;
      end
      step_en_i = 1'b0;
      if (use_abort) begin
         abort_i = 1'b1;
         @(posedge clk); #1;
         abort_i = 1'b0;
         @(negedge clk);
         check("R9 abort ends", int'(valid_o), 0);
      end else begin
         @(negedge clk);
         check("R2 burst end", int'(valid_o), 0);
      end
      check("R2 queue drained", exp_q.size(), 0);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      check("R10 valid", int'(valid_o), 0);
      check("R10 last", int'(last_o), 0);
      check("R10 err", int'(cfg_err_o), 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R10 valid after", int'(valid_o), 0);
      @(posedge clk); #1;

      // sequential fixed bursts with upper bits set
      run_burst(9'h105, 1, 1'b0, 4, 1'b0, 1'b0, "R3 seq4");
      run_burst(9'h0F3, 0, 1'b0, 2, 1'b0, 1'b0, "R3 seq2");
      run_burst(9'h1FE, 2, 1'b0, 8, 1'b1, 1'b0, "R3 seq8 stalled");
      // interleaved
      run_burst(9'h0A5, 2, 1'b1, 8, 1'b0, 1'b0, "R4 il8");
      run_burst(9'h0C3, 1, 1'b1, 4, 1'b1, 1'b0, "R4 il4");
      run_burst(9'h011, 0, 1'b1, 2, 1'b0, 1'b0, "R4 il2");
      // full page across row end
      run_burst(9'h1FC, 3, 1'b0, 9, 1'b1, 1'b1, "R6 page");
      // abort inside a fixed burst
      run_burst(9'h040, 2, 1'b0, 3, 1'b0, 1'b1, "R9 abort fixed");

      // R9: start beats abort in the same cycle
      abort_i = 1'b1;
      launch(9'h123, 1, 1'b0);
      abort_i = 1'b0;
      @(negedge clk);
      check("R9 start priority valid", int'(valid_o), 1);
      check("R9 start priority col", int'(col_o), 9'h123);
      @(posedge clk); #1;
      abort_i = 1'b1;
      @(posedge clk); #1;
      abort_i = 1'b0;

      // R7: illegal request alone
      launch(9'h010, 3, 1'b1);
      @(negedge clk);
      check("R7 err pulse", int'(cfg_err_o), 1);
      check("R7 no burst", int'(valid_o), 0);
      @(posedge clk); #1;
      @(negedge clk);
      check("R7 err one cycle", int'(cfg_err_o), 0);
      check("R7 still idle", int'(valid_o), 0);
      @(posedge clk); #1;

      // R7: illegal request ends a running burst
      cur_req = "R7 prior burst";
      launch(9'h088, 2, 1'b0);
      step_en_i = 1'b1;
      exp_q.push_back(exp_beat(9'h088, 2, 1'b0, 0));
      @(posedge clk); #1;
      step_en_i = 1'b0;
      launch(9'h000, 3, 1'b1);
      @(negedge clk);
      check("R7 err in burst", int'(cfg_err_o), 1);
      check("R7 burst ended", int'(valid_o), 0);
      check("R7 queue drained", exp_q.size(), 0);
      @(posedge clk); #1;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule